// File: doc/BRIEF.md
# Transfer Queue Completion Tracker

This block manages two hardware transfer queues that sit in front of a descriptor-driven DMA engine pair. A submitter presents a transfer with a direction bit. Transfers toward the device go to lane 0 and transfers from the device go to lane 1. Each accepted submission takes one slot of a ring and is answered with a 32-bit sequence handle. Each lane starts its engine on the slot at the head of its ring whenever the engine is idle and work is waiting. It watches the engine's done flag and enable level to detect completion. If a transfer runs longer than a timeout, the lane aborts it.

Every completion is announced by a one-cycle pulse that carries the finished handle and an aborted bit. Completed slots go back to the free pool only when software-side release logic retires them, oldest first, through a per-lane retire strobe. A combinational query port tells whether a handle is still in flight on a lane, using wrap-safe 32-bit arithmetic, and gives the ring slot that holds it.

Top module: `xq_top`

## Requirements
- R1: A submission with `sub_from_dev`=0 goes to lane 0 and one with `sub_from_dev`=1 goes to lane 1. When the lane has a free slot, `sub_ack` pulses one cycle later with `sub_engine` set to the lane and `sub_handle` one greater (mod 2^32) than the previous handle of that lane. The first handle after reset is HANDLE_RESET+1.
- R2: While a lane has no free slot, a submission to it is refused: `sub_nack` pulses one cycle later, and the lane's handle counter does not advance.
- R3: When a lane's engine is idle and submissions are outstanding, the lane pulses `eng_start` with the slot index. Successive starts use slots 0,1,2,… wrapping modulo SLOTS.
- R4: When a transfer is running and `eng_done` is high, the lane pulses `cpl_valid` and `eng_clr_done` together. `cpl_handle` holds the finished handle (handles complete in issue order) and `cpl_aborted` is 0.
- R5: If a running transfer has not completed TIMEOUT cycles after its `eng_start` pulse, the lane pulses `eng_abort`. The timeout then restarts.
- R6: After an abort, the transfer completes when `eng_enable` is low, even with `eng_done` low. Its completion pulse has `cpl_aborted`=1.
- R7: `eng_off` of a lane is high when the lane is idle with nothing outstanding, and low while a transfer is running or waiting.
- R8: A `retire` strobe returns one slot to the free pool only if a completed, not-yet-retired slot exists. Otherwise it is ignored.
- R9: `q_active` is 1 exactly when, in 32-bit modular arithmetic, (done count − handle) > 2^23 and (issued count − handle) ≤ 2^23.
- R10: For an active handle, `q_slot` = (handle − done count + current slot − 1) reduced once modulo SLOTS.
- R11: After reset both `eng_off` bits are 1, and no ack, start, abort or completion pulse is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sub_valid | input | 1 | Submission request, one cycle |
| sub_from_dev | input | 1 | Direction: 0 to device (lane 0), 1 from device (lane 1) |
| retire | input | 2 | Per-lane strobe retiring the oldest completed slot |
| eng_done | input | 2 | Per-lane engine transfer-done flag |
| eng_enable | input | 2 | Per-lane engine enable level |
| q_engine | input | 1 | Lane selected by the query |
| q_handle | input | HW | Handle being queried |
| sub_ack | output | 1 | Submission accepted |
| sub_nack | output | 1 | Submission refused |
| sub_engine | output | 1 | Lane of the answered submission |
| sub_handle | output | HW | Handle assigned to the accepted submission |
| eng_start | output | 2 | Per-lane start pulse |
| eng_slot | output | 2*IW | Per-lane slot index of the start |
| eng_abort | output | 2 | Per-lane abort pulse |
| eng_clr_done | output | 2 | Per-lane clear of the done flag |
| eng_off | output | 2 | Per-lane engine switch-off level |
| cpl_valid | output | 2 | Per-lane completion pulse |
| cpl_handle | output | 2*HW | Per-lane completed handle |
| cpl_aborted | output | 2 | Per-lane aborted marker of the completion |
| q_active | output | 1 | Queried handle is in flight |
| q_slot | output | IW | Ring slot of the queried handle |

## Verification
A corrupted issued or done counter shows up at once as an off-by-one handle on the next ack or completion pulse. It also shows as a wrong `q_active` answer near the edges of the window, for example a handle that has just finished or one that has not been issued yet. A lost current-slot or outstanding count appears within one transfer as a start on the wrong slot, or as a stuck `eng_off`. A free-count error becomes visible only when the ring fills: an early or missing refusal, or a retire that hands back a slot for work that has not finished. The timeout counter is checked directly as the exact distance between start and abort.

// File: rtl/xq_pkg.sv
package xq_pkg;
  localparam int unsigned LANES = 2;
  localparam int unsigned WIN_LOG2 = 23;
endpackage

// File: rtl/xq_window.sv
module xq_window #(
  parameter int unsigned HW    = 32,
  parameter int unsigned SLOTS = 8,
  parameter int unsigned IW    = $clog2(SLOTS)
) (
  input  logic [HW-1:0] handle,
  input  logic [HW-1:0] issued,
  input  logic [HW-1:0] done,
  input  logic [IW-1:0] cur,
  output logic          active,
  output logic [IW-1:0] slot
);
  localparam logic [HW-1:0] WIN = HW'(1) << xq_pkg::WIN_LOG2;
  localparam int unsigned SW = IW + 2;

  logic [HW-1:0] ahead;
  logic [SW-1:0] sum;

  always_comb begin
    active = ((done - handle) > WIN) && ((issued - handle) <= WIN);
    ahead  = handle - done;
    sum    = ahead[SW-1:0] + SW'(cur) - SW'(1);
    if (sum >= SW'(SLOTS)) sum = sum - SW'(SLOTS);
    slot   = active ? sum[IW-1:0] : '0;
  end
endmodule

// File: rtl/xq_lane.sv
module xq_lane #(
  parameter int unsigned HW           = 32,
  parameter int unsigned SLOTS        = 8,
  parameter int unsigned TIMEOUT      = 1000,
  parameter logic [HW-1:0] HANDLE_RESET = '0,
  parameter int unsigned IW           = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sub_req,
  input  logic          retire,
  input  logic          done_flag,
  input  logic          en_flag,
  output logic          sub_ok,
  output logic [HW-1:0] next_handle,
  output logic          start,
  output logic [IW-1:0] slot,
  output logic          abort,
  output logic          clr_done,
  output logic          off,
  output logic          cpl,
  output logic [HW-1:0] cpl_h,
  output logic          cpl_ab,
  output logic [HW-1:0] issued_o,
  output logic [HW-1:0] done_o,
  output logic [IW-1:0] cur_o
);
  localparam int unsigned CW = $clog2(SLOTS + 1);
  localparam int unsigned TW = $clog2(TIMEOUT + 1);

  logic [HW-1:0] issued_q, done_q;
  logic [IW-1:0] cur_q;
  logic [CW-1:0] free_q, outst_q, pend_q;
  logic          active_q, aborting_q;
  logic [TW-1:0] tmr_q;
  logic          fin, launch, ret_ok;

  assign sub_ok      = sub_req && (free_q != '0);
  assign next_handle = issued_q + HW'(1);
  assign fin    = (active_q && done_flag) || (aborting_q && !en_flag);
  assign launch = !active_q && (outst_q != '0);
  assign ret_ok = retire && (pend_q != '0);
  assign issued_o = issued_q;
  assign done_o   = done_q;
  assign cur_o    = cur_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      issued_q   <= HANDLE_RESET;
      done_q     <= HANDLE_RESET;
      cur_q      <= '0;
      free_q     <= CW'(SLOTS);
      outst_q    <= '0;
      pend_q     <= '0;
      active_q   <= 1'b0;
      aborting_q <= 1'b0;
      tmr_q      <= '0;
      start      <= 1'b0;
      slot       <= '0;
      abort      <= 1'b0;
      clr_done   <= 1'b0;
      off        <= 1'b1;
      cpl        <= 1'b0;
      cpl_h      <= '0;
      cpl_ab     <= 1'b0;
    end else begin
      start    <= 1'b0;
      abort    <= 1'b0;
      clr_done <= 1'b0;
      cpl      <= 1'b0;
      if (sub_ok) issued_q <= issued_q + HW'(1);
      free_q  <= free_q - CW'(sub_ok) + CW'(ret_ok);
      outst_q <= outst_q + CW'(sub_ok) - CW'(launch);
      pend_q  <= pend_q + CW'(fin) - CW'(ret_ok);
      off     <= !active_q && (outst_q == '0);
      if (fin) begin
        done_q     <= done_q + HW'(1);
        cur_q      <= (cur_q == IW'(SLOTS - 1)) ? '0 : cur_q + IW'(1);
        active_q   <= 1'b0;
        aborting_q <= 1'b0;
        clr_done   <= 1'b1;
        cpl        <= 1'b1;
        cpl_h      <= done_q + HW'(1);
        cpl_ab     <= aborting_q;
      end else if (launch) begin
        active_q <= 1'b1;
        tmr_q    <= TW'(TIMEOUT - 1);
        start    <= 1'b1;
        slot     <= cur_q;
      end else if (active_q) begin
        if (tmr_q == '0) begin
          abort      <= 1'b1;
          aborting_q <= 1'b1;
          tmr_q      <= TW'(TIMEOUT - 1);
        end else begin
          tmr_q <= tmr_q - TW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/xq_top.sv
module xq_top #(
  parameter int unsigned HW             = 32,
  parameter int unsigned SLOTS          = 8,
  parameter int unsigned TIMEOUT        = 1000,
  parameter logic [HW-1:0] HANDLE_RESET = '0,
  parameter int unsigned IW             = $clog2(SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sub_valid,
  input  logic                 sub_from_dev,
  input  logic [1:0]           retire,
  input  logic [1:0]           eng_done,
  input  logic [1:0]           eng_enable,
  input  logic                 q_engine,
  input  logic [HW-1:0]        q_handle,
  output logic                 sub_ack,
  output logic                 sub_nack,
  output logic                 sub_engine,
  output logic [HW-1:0]        sub_handle,
  output logic [1:0]           eng_start,
  output logic [2*IW-1:0]      eng_slot,
  output logic [1:0]           eng_abort,
  output logic [1:0]           eng_clr_done,
  output logic [1:0]           eng_off,
  output logic [1:0]           cpl_valid,
  output logic [2*HW-1:0]      cpl_handle,
  output logic [1:0]           cpl_aborted,
  output logic                 q_active,
  output logic [IW-1:0]        q_slot
);
  localparam int unsigned NL = xq_pkg::LANES;

  logic [NL-1:0]    ok;
  logic [HW-1:0]    nh     [NL];
  logic [HW-1:0]    iss    [NL];
  logic [HW-1:0]    dn     [NL];
  logic [IW-1:0]    cur    [NL];

  for (genvar e = 0; e < NL; e++) begin : g_lane
    xq_lane #(
      .HW(HW), .SLOTS(SLOTS), .TIMEOUT(TIMEOUT),
      .HANDLE_RESET(HANDLE_RESET), .IW(IW)
    ) u_lane (
      .clk(clk), .rst(rst),
      .sub_req(sub_valid && (sub_from_dev == e[0])),
      .retire(retire[e]),
      .done_flag(eng_done[e]),
      .en_flag(eng_enable[e]),
      .sub_ok(ok[e]),
      .next_handle(nh[e]),
      .start(eng_start[e]),
      .slot(eng_slot[e*IW +: IW]),
      .abort(eng_abort[e]),
      .clr_done(eng_clr_done[e]),
      .off(eng_off[e]),
      .cpl(cpl_valid[e]),
      .cpl_h(cpl_handle[e*HW +: HW]),
      .cpl_ab(cpl_aborted[e]),
      .issued_o(iss[e]),
      .done_o(dn[e]),
      .cur_o(cur[e])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sub_ack    <= 1'b0;
      sub_nack   <= 1'b0;
      sub_engine <= 1'b0;
      sub_handle <= '0;
    end else begin
      sub_ack    <= |ok;
      sub_nack   <= sub_valid && !(|ok);
      sub_engine <= sub_from_dev;
      if (|ok) sub_handle <= nh[sub_from_dev];
    end
  end

  xq_window #(.HW(HW), .SLOTS(SLOTS), .IW(IW)) u_win (
    .handle(q_handle),
    .issued(iss[q_engine]),
    .done(dn[q_engine]),
    .cur(cur[q_engine]),
    .active(q_active),
    .slot(q_slot)
  );
endmodule

// File: rtl/xq_chk.sv
module xq_chk #(
  parameter int unsigned HW = 32,
  parameter int unsigned IW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          sub_ack,
  input logic          sub_nack,
  input logic          sub_engine,
  input logic [HW-1:0] sub_handle,
  input logic [1:0]    eng_start,
  input logic [1:0]    eng_abort,
  input logic [1:0]    eng_clr_done,
  input logic [1:0]    eng_off,
  input logic [1:0]    cpl_valid
);
  logic [HW-1:0] last_h [2];
  logic [1:0]    seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen      <= '0;
      last_h[0] <= '0;
      last_h[1] <= '0;
    end else if (sub_ack) begin
      last_h[sub_engine] <= sub_handle;
      seen[sub_engine]   <= 1'b1;
    end
  end

  // R1
  handle_step_chk: assert property (@(posedge clk) disable iff (rst)
    sub_ack && seen[sub_engine] |-> sub_handle == last_h[sub_engine] + HW'(1));

  // R2
  ack_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(sub_ack && sub_nack));

  for (genvar e = 0; e < 2; e++) begin : g_e
    // R3
    start_off_chk: assert property (@(posedge clk) disable iff (rst)
      eng_start[e] |-> !eng_off[e]);
    // R4
    cpl_clear_chk: assert property (@(posedge clk) disable iff (rst)
      cpl_valid[e] |-> eng_clr_done[e]);
    // R4
    cpl_gap_chk: assert property (@(posedge clk) disable iff (rst)
      cpl_valid[e] |=> !cpl_valid[e]);
    // R5
    abort_gap_chk: assert property (@(posedge clk) disable iff (rst)
      eng_abort[e] |=> !eng_abort[e]);
    // R7
    abort_off_chk: assert property (@(posedge clk) disable iff (rst)
      eng_abort[e] |-> !eng_off[e]);
  end
endmodule

bind xq_top xq_chk #(.HW(HW), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .sub_ack(sub_ack), .sub_nack(sub_nack),
  .sub_engine(sub_engine), .sub_handle(sub_handle), .eng_start(eng_start),
  .eng_abort(eng_abort), .eng_clr_done(eng_clr_done), .eng_off(eng_off),
  .cpl_valid(cpl_valid)
);

// File: tb/tb_xq_top.sv
`timescale 1ns/1ps
module tb_xq_top;
  localparam int HW = 32;
  localparam int SLOTS = 8;
  localparam int IW = 3;
  localparam int TO = 200;
  localparam logic [31:0] HR = 32'hFFFF_FFFD;

  logic clk = 0, rst = 1;
  logic sub_valid = 0, sub_from_dev = 0;
  logic [1:0] retire = 0, done_r = 0, en_r = 0;
  logic q_engine = 0;
  logic [31:0] q_handle = 0;
  logic sub_ack, sub_nack, sub_engine;
  logic [31:0] sub_handle;
  logic [1:0] eng_start, eng_abort, eng_clr_done, eng_off, cpl_valid, cpl_aborted;
  logic [2*IW-1:0] eng_slot;
  logic [63:0] cpl_handle;
  logic q_active;
  logic [IW-1:0] q_slot;

  always #4 clk = ~clk;

  xq_top #(.HW(HW), .SLOTS(SLOTS), .TIMEOUT(TO), .HANDLE_RESET(HR)) dut (
    .clk(clk), .rst(rst), .sub_valid(sub_valid), .sub_from_dev(sub_from_dev),
    .retire(retire), .eng_done(done_r), .eng_enable(en_r), .q_engine(q_engine),
    .q_handle(q_handle), .sub_ack(sub_ack), .sub_nack(sub_nack),
    .sub_engine(sub_engine), .sub_handle(sub_handle), .eng_start(eng_start),
    .eng_slot(eng_slot), .eng_abort(eng_abort), .eng_clr_done(eng_clr_done),
    .eng_off(eng_off), .cpl_valid(cpl_valid), .cpl_handle(cpl_handle),
    .cpl_aborted(cpl_aborted), .q_active(q_active), .q_slot(q_slot));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int drv_cmp = 0, drv_bad = 0, mon_cmp = 0, mon_bad = 0, wd_bad = 0;
  logic [33:0] expq [$];
  logic [31:0] iss [2];
  logic [31:0] dn [2];
  int nc [2], exp_slot [2], start_cyc [2], n_ab [2], kick [2], kseen [2];
  logic [1:0] ab_seen = 0, auto_d = 0;

  initial begin
    for (int e = 0; e < 2; e++) begin
      iss[e] = HR; dn[e] = HR; nc[e] = 0; exp_slot[e] = 0; start_cyc[e] = 0;
      n_ab[e] = 0; kick[e] = 0; kseen[e] = 0;
    end
  end

  // scoreboard monitor and engine model
  always @(negedge clk) begin
    if (!rst) begin
      for (int e = 0; e < 2; e++) begin
        if (kick[e] != kseen[e]) begin done_r[e] = 1'b1; kseen[e] = kick[e]; end
        if (eng_start[e]) begin
          mon_cmp++;
          if (eng_slot[e*IW +: IW] != exp_slot[e][IW-1:0]) begin
            mon_bad++;
            $display("FAIL R3 lane%0d start slot %0d expected %0d", e, eng_slot[e*IW +: IW], exp_slot[e]);
          end
          exp_slot[e] = (exp_slot[e] + 1) % SLOTS;
          start_cyc[e] = cyc;
          en_r[e] = 1'b1;
          if (auto_d[e]) done_r[e] = 1'b1;
        end
        if (eng_abort[e]) begin
          if (!ab_seen[e]) begin
            mon_cmp++;
            if (cyc - start_cyc[e] != TO) begin
              mon_bad++;
              $display("FAIL R5 abort delay %0d expected %0d", cyc - start_cyc[e], TO);
            end
          end
          ab_seen[e] = 1'b1;
          n_ab[e]++;
          en_r[e] = 1'b0;
        end
        if (cpl_valid[e]) begin
          mon_cmp++;
          if (cpl_handle[e*HW +: HW] != dn[e] + 1 || cpl_aborted[e] != ab_seen[e] || !eng_clr_done[e]) begin
            mon_bad++;
            $display("FAIL R4/R6 lane%0d cpl h=%h ab=%b clr=%b expected h=%h ab=%b clr=1",
                     e, cpl_handle[e*HW +: HW], cpl_aborted[e], eng_clr_done[e], dn[e] + 1, ab_seen[e]);
          end
          dn[e] = dn[e] + 1;
          nc[e]++;
          ab_seen[e] = 1'b0;
        end
        if (eng_clr_done[e]) begin done_r[e] = 1'b0; en_r[e] = 1'b0; end
      end
      if (sub_ack || sub_nack) begin
        mon_cmp++;
        if (expq.size() == 0) begin
          mon_bad++;
          $display("FAIL R1/R2 unexpected answer ack=%b nack=%b expected none", sub_ack, sub_nack);
        end else begin
          logic [33:0] x;
          x = expq.pop_front();
          if (sub_nack != x[33] || sub_engine != x[32] || (sub_ack && sub_handle != x[31:0])) begin
            mon_bad++;
            $display("FAIL R1/R2 got nack=%b eng=%b h=%h expected nack=%b eng=%b h=%h",
                     sub_nack, sub_engine, sub_handle, x[33], x[32], x[31:0]);
          end
        end
      end
    end
  end

  task automatic chk(input bit c, input string req, input logic [31:0] act, input logic [31:0] exp);
    drv_cmp++;
    if (!c) begin
      drv_bad++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic submit(input bit dir, input bit ok);
    if (ok) begin
      iss[dir] = iss[dir] + 1;
      expq.push_back({1'b0, dir, iss[dir]});
    end else expq.push_back({1'b1, dir, 32'h0});
    @(negedge clk); sub_valid = 1; sub_from_dev = dir;
    @(negedge clk); sub_valid = 0;
  endtask

  task automatic retire_one(input int e);
    @(negedge clk); retire[e] = 1;
    @(negedge clk); retire = 0;
  endtask

  task automatic query(input bit e, input logic [31:0] h, input string req);
    logic ea;
    int es;
    @(negedge clk); q_engine = e; q_handle = h;
    #1;
    ea = ((dn[e] - h) > 32'h0080_0000) && ((iss[e] - h) <= 32'h0080_0000);
    chk(q_active == ea, {req, " active"}, {31'b0, q_active}, {31'b0, ea});
    if (ea) begin
      es = (int'(h - dn[e]) + (nc[e] % SLOTS) - 1) % SLOTS;
      chk(q_slot == es[IW-1:0], "R10 slot", {29'b0, q_slot}, es);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // watchdog
  initial begin
    #(8 * 50000);
    wd_bad = 1;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***",
             drv_cmp + mon_cmp + 1, drv_bad + mon_bad + 1);
    $finish;
  end

  initial begin
    idle(3); rst = 0;
    idle(1);
    // R11 reset state
    chk(eng_off == 2'b11 && cpl_valid == 0 && eng_start == 0 && !sub_ack, "R11 reset",
        {30'b0, eng_off}, 32'h3);
    query(0, HR + 1, "R9 not yet issued");
    // R1 first handle, lane 0
    submit(0, 1);
    idle(3);
    query(0, HR + 1, "R9 in flight");
    chk(eng_off[0] == 0, "R7 busy", {31'b0, eng_off[0]}, 0);
    submit(0, 1); submit(0, 1);
    idle(2);
    query(0, 32'h0, "R9 wrapped handle");
    query(0, 32'h1, "R9 future handle");
    // R4 normal completion
    kick[0]++;
    idle(5);
    query(0, HR + 1, "R9 finished handle");
    // R5/R6 timeout abort on second transfer
    for (int i = 0; i < 3 * TO && n_ab[0] == 0; i++) idle(1);
    chk(n_ab[0] == 1, "R5 abort seen", n_ab[0], 1);
    idle(5);
    chk(nc[0] == 2, "R6 aborted completion count", nc[0], 2);
    kick[0]++;
    idle(6);
    chk(nc[0] == 3 && eng_off[0] == 1, "R7 idle off", {31'b0, eng_off[0]}, 1);
    // R8 retire gating, R2 refusal
    submit(0, 1);
    for (int i = 0; i < 4; i++) retire_one(0);
    for (int i = 0; i < 7; i++) submit(0, 1);
    submit(0, 0);
    idle(2);
    query(0, dn[0] + 2, "R9 queued");
    query(0, dn[0] + 5, "R9 queued deeper");
    auto_d[0] = 1;
    kick[0]++;
    idle(120);
    chk(dn[0] == iss[0] && eng_off[0] == 1, "R4 drained", dn[0], iss[0]);
    chk(expq.size() == 0, "R1 answers consumed", expq.size(), 0);
    // R1 lane 1 routing
    submit(1, 1);
    idle(3);
    query(1, HR + 1, "R9 lane1");
    kick[1]++;
    idle(6);
    chk(nc[1] == 1 && eng_off == 2'b11, "R7 both off", {30'b0, eng_off}, 3);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***",
             drv_cmp + mon_cmp, drv_bad + mon_bad + wd_bad);
    $finish;
  end
endmodule